// File: doc/BRIEF.md
# Six-Pin GPIO Port with Edge Interrupts

This block is a memory-mapped general-purpose I/O port of six pins for a small 8-bit microcontroller bus. Software programs each pin as an input, a push-pull output, an open-drain output or an alternate-function pin. It can also switch on a pull-up for each pin. The block turns these settings into per-pin pad controls: drive enable, drive value, pull-up enable and an alternate-function select. The peripherals behind the alternate functions lie outside the block.

Every pin can request an interrupt on a chosen edge, rising or falling. Pad levels pass through a two-flop synchronizer. An edge is seen by comparing the synchronized level with its copy from one cycle earlier. A detected edge on an enabled pin sets a sticky pending flag. The active-low interrupt line stays low while any flag is set. Software clears a flag by writing zero to it. If a clear and a new edge land in the same cycle, the new edge wins.

The bus is a plain single-cycle write strobe with a combinational read of the addressed register. Unused bits and unmapped addresses read as zero.

Top module: `gpio6_port`

## Requirements
- R1: A write to address E6h loads the output latch from data bits 5:0. A read of E6h returns the pad levels after the two-flop synchronizer, so a pad change shows up in the read two clock edges later.
- R2: Mode fields are 2 bits per pin. The code 00 selects input, 01 push-pull, 10 open-drain and 11 alternate function. Register E9h holds pins 0, 1 and 2 in bits 1:0, 3:2 and 5:4. Register E8h holds pins 3, 4 and 5 in the same positions. A push-pull pin drives its latch value with the drive enable on. An input pin and an alternate-function pin keep the drive enable off.
- R3: Reset (synchronous, active high) clears the latch, the mode, pull-up, interrupt enable, edge select and pending registers to zero. After reset every pin is an input, all drive enables are off, no alternate select is set and the interrupt line is high.
- R4: Bits 5:0 of register F4h drive the per-pin pull-up enables directly.
- R5: An open-drain pin with latch 0 is driven low with its drive enable on. With latch 1 its drive enable is off. The drive value of an open-drain pin is always 0.
- R6: A pin in alternate-function mode raises its alternate select output and never has its drive enable on.
- R7: The edge select for pins 0 to 2 sits in bits 2:0 of F7h, and for pins 3 to 5 in bits 2:0 of F6h. A 1 selects the rising edge and a 0 selects the falling edge. When a pin's enable bit in F5h is 1 and its selected edge reaches the pad, pending bit n at D7h is set on the third clock edge after the pad change.
- R8: An edge does not set a pending bit if that pin's interrupt enable is 0, or if the edge is the opposite one to the pin's selection.
- R9: The interrupt line is low exactly while at least one pending bit is 1.
- R10: Writing 0 to a pending bit clears it. Writing 1 leaves it unchanged. No other access changes a pending bit except a detected edge.
- R11: When a detected edge and a software clear hit the same pending bit on the same clock edge, the bit ends up set.
- R12: Register bits 7:6 read as 0, and any address not in the map reads as 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 6 | Raw pad levels |
| pad_out | output | 6 | Pad drive value |
| pad_oe | output | 6 | Pad drive enable |
| pad_pu | output | 6 | Pad pull-up enable |
| alt_sel | output | 6 | Alternate-function select per pin |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Register writes and pad-control outputs take effect on the clock edge that accepts the write, and a register read is valid in the same cycle as its address. A pad change reaches the data readback after two edges and a pending bit after three edges, and the interrupt line follows the pending bit with no extra delay. The bench drives inputs on falling edges and updates a behavioural model on each rising edge. One nanosecond after every rising edge it compares all outputs and the read data. The directed checks count edges to the due cycle, so the third-edge interrupt latency is also checked one edge early, when the line must still be high.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;

    localparam int PORT_PINS = 6;
    localparam int BUS_DW    = 8;
    localparam int BUS_AW    = 8;

    // register map
    localparam logic [7:0] ADR_DATA   = 8'hE6;
    localparam logic [7:0] ADR_MODEHI = 8'hE8;
    localparam logic [7:0] ADR_MODELO = 8'hE9;
    localparam logic [7:0] ADR_PULL   = 8'hF4;
    localparam logic [7:0] ADR_IEN    = 8'hF5;
    localparam logic [7:0] ADR_EDGHI  = 8'hF6;
    localparam logic [7:0] ADR_EDGLO  = 8'hF7;
    localparam logic [7:0] ADR_PEND   = 8'hD7;

    typedef enum logic [1:0] {
        MODE_IN  = 2'b00,
        MODE_PP  = 2'b01,
        MODE_OD  = 2'b10,
        MODE_ALT = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic alt;
    } pad_drv_t;

    // per-pin pad drive derived from mode and latch bit
    function automatic pad_drv_t drive_for(input pin_mode_e m, input logic lat);
        pad_drv_t d;
        d.oe  = 1'b0;
        d.out = lat;
        d.alt = 1'b0;
        case (m)
            MODE_PP:  d.oe = 1'b1;
            MODE_OD: begin
                d.oe  = ~lat;
                d.out = 1'b0;
            end
            MODE_ALT: d.alt = 1'b1;
            default:  ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpio6_sync_edge.sv
module gpio6_sync_edge #(
    parameter int NPINS = gpio6_pkg::PORT_PINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] rise_sel,
    output logic [NPINS-1:0] pin_lvl,
    output logic [NPINS-1:0] hit
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pad_in[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign pin_lvl[i] = sync_q;
        assign hit[i]     = rise_sel[i] ? (sync_q & ~prev_q) : (~sync_q & prev_q);
    end

endmodule

// File: rtl/gpio6_regs.sv
module gpio6_regs
    import gpio6_pkg::*;
#(
    parameter int NPINS = PORT_PINS,
    parameter int DW    = BUS_DW,
    parameter int AW    = BUS_AW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    input  logic [NPINS-1:0]      pin_lvl,
    input  logic [NPINS-1:0]      hit,
    output logic [DW-1:0]         rdata,
    output logic [NPINS-1:0]      lat_q,
    output pin_mode_e [NPINS-1:0] mode,
    output logic [NPINS-1:0]      pu_q,
    output logic [NPINS-1:0]      ien_q,
    output logic [NPINS-1:0]      rise_sel,
    output logic [NPINS-1:0]      pend_q
);

    localparam int HALF = NPINS / 2;
    localparam int CW   = 2 * HALF;

    logic [CW-1:0]    ctl_lo_q;
    logic [CW-1:0]    ctl_hi_q;
    logic [HALF-1:0]  esel_lo_q;
    logic [HALF-1:0]  esel_hi_q;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] pend_d;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DW-1:NPINS];

    for (genvar i = 0; i < HALF; i++) begin : g_mode
        assign mode[i]        = pin_mode_e'(ctl_lo_q[2*i +: 2]);
        assign mode[i + HALF] = pin_mode_e'(ctl_hi_q[2*i +: 2]);
    end

    assign rise_sel = {esel_hi_q, esel_lo_q};

    // a write of 0 clears; a fresh edge overrides the clear
    always_comb begin
        clr_mask = '1;
        if (wr_en && addr == ADR_PEND) clr_mask = wdata[NPINS-1:0];
        pend_d = (pend_q & clr_mask) | (hit & ien_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q     <= '0;
            ctl_lo_q  <= '0;
            ctl_hi_q  <= '0;
            pu_q      <= '0;
            ien_q     <= '0;
            esel_lo_q <= '0;
            esel_hi_q <= '0;
            pend_q    <= '0;
        end else begin
            pend_q <= pend_d;
            if (wr_en) begin
                case (addr)
                    ADR_DATA:   lat_q     <= wdata[NPINS-1:0];
                    ADR_MODELO: ctl_lo_q  <= wdata[CW-1:0];
                    ADR_MODEHI: ctl_hi_q  <= wdata[CW-1:0];
                    ADR_PULL:   pu_q      <= wdata[NPINS-1:0];
                    ADR_IEN:    ien_q     <= wdata[NPINS-1:0];
                    ADR_EDGLO:  esel_lo_q <= wdata[HALF-1:0];
                    ADR_EDGHI:  esel_hi_q <= wdata[HALF-1:0];
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_DATA:   rdata[NPINS-1:0] = pin_lvl;
            ADR_MODELO: rdata[CW-1:0]    = ctl_lo_q;
            ADR_MODEHI: rdata[CW-1:0]    = ctl_hi_q;
            ADR_PULL:   rdata[NPINS-1:0] = pu_q;
            ADR_IEN:    rdata[NPINS-1:0] = ien_q;
            ADR_EDGLO:  rdata[HALF-1:0]  = esel_lo_q;
            ADR_EDGHI:  rdata[HALF-1:0]  = esel_hi_q;
            ADR_PEND:   rdata[NPINS-1:0] = pend_q;
            default:    ;
        endcase
    end

endmodule

// File: rtl/gpio6_pad_ctrl.sv
module gpio6_pad_ctrl
    import gpio6_pkg::*;
#(
    parameter int NPINS = PORT_PINS
) (
    input  pin_mode_e [NPINS-1:0] mode,
    input  logic [NPINS-1:0]      lat,
    output logic [NPINS-1:0]      oe,
    output logic [NPINS-1:0]      out,
    output logic [NPINS-1:0]      alt
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pad
        pad_drv_t drv;
        assign drv    = drive_for(mode[i], lat[i]);
        assign oe[i]  = drv.oe;
        assign out[i] = drv.out;
        assign alt[i] = drv.alt;
    end

endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
    import gpio6_pkg::*;
#(
    parameter int NPINS = PORT_PINS,
    parameter int DW    = BUS_DW,
    parameter int AW    = BUS_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pu,
    output logic [NPINS-1:0] alt_sel,
    output logic             irq_n
);

    logic [NPINS-1:0]      pin_lvl;
    logic [NPINS-1:0]      hit;
    logic [NPINS-1:0]      lat_w;
    logic [NPINS-1:0]      ien_w;
    logic [NPINS-1:0]      rise_w;
    logic [NPINS-1:0]      pend_w;
    pin_mode_e [NPINS-1:0] mode_w;

    gpio6_sync_edge #(.NPINS(NPINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .rise_sel (rise_w),
        .pin_lvl  (pin_lvl),
        .hit      (hit)
    );

    gpio6_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_lvl  (pin_lvl),
        .hit      (hit),
        .rdata    (bus_rdata),
        .lat_q    (lat_w),
        .mode     (mode_w),
        .pu_q     (pad_pu),
        .ien_q    (ien_w),
        .rise_sel (rise_w),
        .pend_q   (pend_w)
    );

    gpio6_pad_ctrl #(.NPINS(NPINS)) u_pad (
        .mode (mode_w),
        .lat  (lat_w),
        .oe   (pad_oe),
        .out  (pad_out),
        .alt  (alt_sel)
    );

    assign irq_n = ~|pend_w;

endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk #(
    parameter int NPINS = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       bus_addr,
    input logic             bus_wr,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] alt_sel,
    input logic             irq_n,
    input logic [NPINS-1:0] pend_q,
    input logic [NPINS-1:0] ien_q,
    input logic [NPINS-1:0] lat_q
);

    // R3
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (irq_n && pad_oe == '0 && alt_sel == '0));

    // R6
    alt_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (alt_sel & pad_oe) == '0);

    // R8
    pend_needs_ien_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(ien_q)) == '0));

    // R10
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 8'hD7) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R1
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 8'hE6) |=> $stable(lat_q));

endmodule

bind gpio6_port gpio6_port_chk #(.NPINS(NPINS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .pad_oe   (pad_oe),
    .alt_sel  (alt_sel),
    .irq_n    (irq_n),
    .pend_q   (pend_w),
    .ien_q    (ien_w),
    .lat_q    (lat_w)
);

// File: tb/gpio6_port_tb.sv
`timescale 1ns/1ps
module gpio6_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [5:0] pad_in = 6'h00;
    logic [5:0] pad_out, pad_oe, pad_pu, alt_sel;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio6_port dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .alt_sel(alt_sel), .irq_n(irq_n)
    );

    // behavioural reference state
    bit [5:0] m_lat, m_pu, m_ie, m_rise, m_pend, m_s1, m_s2, m_d;
    int       m_mode[6];

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] m_read(logic [7:0] a);
        logic [7:0] r = 8'h00;
        case (a)
            8'hE6: r = {2'b00, m_s2};
            8'hE9: for (int i = 0; i < 3; i++) r[2*i +: 2] = m_mode[i][1:0];
            8'hE8: for (int i = 0; i < 3; i++) r[2*i +: 2] = m_mode[i+3][1:0];
            8'hF4: r = {2'b00, m_pu};
            8'hF5: r = {2'b00, m_ie};
            8'hF7: r = {5'b0, m_rise[2:0]};
            8'hF6: r = {5'b0, m_rise[5:3]};
            8'hD7: r = {2'b00, m_pend};
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        bit [5:0] np;
        bit [5:0] e_oe, e_out, e_alt;
        if (rst) begin
            m_lat = 0; m_pu = 0; m_ie = 0; m_rise = 0; m_pend = 0;
            m_s1 = 0; m_s2 = 0; m_d = 0;
            for (int i = 0; i < 6; i++) m_mode[i] = 0;
        end else begin
            np = m_pend;
            if (bus_wr && bus_addr == 8'hD7) np = np & bus_wdata[5:0];
            for (int i = 0; i < 6; i++) begin
                if (m_ie[i] && m_rise[i] && m_s2[i] && !m_d[i]) np[i] = 1'b1;
                if (m_ie[i] && !m_rise[i] && !m_s2[i] && m_d[i]) np[i] = 1'b1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'hE6: m_lat = bus_wdata[5:0];
                    8'hE9: for (int i = 0; i < 3; i++) m_mode[i] = int'(bus_wdata[2*i +: 2]);
                    8'hE8: for (int i = 0; i < 3; i++) m_mode[i+3] = int'(bus_wdata[2*i +: 2]);
                    8'hF4: m_pu = bus_wdata[5:0];
                    8'hF5: m_ie = bus_wdata[5:0];
                    8'hF7: m_rise[2:0] = bus_wdata[2:0];
                    8'hF6: m_rise[5:3] = bus_wdata[2:0];
                    default: ;
                endcase
            end
            m_d = m_s2; m_s2 = m_s1; m_s1 = pad_in;
            m_pend = np;
        end
        #1;
        for (int i = 0; i < 6; i++) begin
            e_oe[i]  = (m_mode[i] == 1) || (m_mode[i] == 2 && !m_lat[i]);
            e_out[i] = (m_mode[i] == 2) ? 1'b0 : m_lat[i];
            e_alt[i] = (m_mode[i] == 3);
        end
        check("R2 pad_oe", {2'b0, pad_oe}, {2'b0, e_oe});
        check("R5 pad_out", {2'b0, pad_out}, {2'b0, e_out});
        check("R4 pad_pu", {2'b0, pad_pu}, {2'b0, m_pu});
        check("R6 alt_sel", {2'b0, alt_sel}, {2'b0, e_alt});
        check("R9 irq_n", {7'b0, irq_n}, {7'b0, (m_pend == 0)});
        check("R1/R12 rdata", bus_rdata, m_read(bus_addr));
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3 reset state
        rd(8'hE9, 8'h00, "R3 mode lo");
        rd(8'hE8, 8'h00, "R3 mode hi");
        rd(8'hD7, 8'h00, "R3 pending");
        check("R3 irq_n", {7'b0, irq_n}, 8'h01);
        check("R3 pad_oe", {2'b0, pad_oe}, 8'h00);

        // R2 R5 R6 modes
        wr(8'hE9, 8'h39);
        wr(8'hE8, 8'h24);
        wr(8'hE6, 8'h2A);
        #1;
        check("R2 oe mixed", {2'b0, pad_oe}, 8'h11);
        check("R5 od released", {2'b0, pad_out}, 8'h08);
        check("R6 alt", {2'b0, alt_sel}, 8'h04);
        wr(8'hE6, 8'h15);
        #1;
        check("R5 od driven low", {2'b0, pad_oe}, 8'h33);
        check("R5 od value", {2'b0, pad_out}, 8'h15);

        // R1 readback through synchronizer
        @(negedge clk); pad_in = 6'h2D;
        @(negedge clk);
        @(negedge clk);
        rd(8'hE6, 8'h2D, "R1 pin readback");

        // R12 R4
        wr(8'hE9, 8'hFF);
        rd(8'hE9, 8'h3F, "R12 unused bits");
        rd(8'h00, 8'h00, "R12 unmapped");
        wr(8'hF4, 8'hFF);
        rd(8'hF4, 8'h3F, "R4 pull readback");
        check("R4 pad_pu", {2'b0, pad_pu}, 8'h3F);

        // R7 R8 R9 low pins
        @(negedge clk); pad_in = 6'h00;
        repeat (4) @(negedge clk);
        wr(8'hF5, 8'h05);
        wr(8'hF7, 8'h01);
        wr(8'hF6, 8'h00);
        @(negedge clk); pad_in = 6'h07;
        repeat (4) @(negedge clk);
        rd(8'hD7, 8'h01, "R7 R8 rising pin0 only");
        check("R9 irq low", {7'b0, irq_n}, 8'h00);
        @(negedge clk); pad_in = 6'h00;
        repeat (4) @(negedge clk);
        rd(8'hD7, 8'h05, "R7 falling pin2");
        wr(8'hD7, 8'hFE);
        rd(8'hD7, 8'h04, "R10 clear by zero");
        wr(8'hD7, 8'hFF);
        rd(8'hD7, 8'h04, "R10 one keeps");
        wr(8'hD7, 8'h00);
        rd(8'hD7, 8'h00, "R10 clear all");
        check("R9 irq high", {7'b0, irq_n}, 8'h01);

        // R7 latency on high pins
        wr(8'hF5, 8'h38);
        wr(8'hF6, 8'h02);
        @(negedge clk); pad_in = 6'h18;
        @(negedge clk);
        @(negedge clk);
        check("R7 not yet at edge 2", {7'b0, irq_n}, 8'h01);
        @(negedge clk);
        check("R7 set at edge 3", {7'b0, irq_n}, 8'h00);
        rd(8'hD7, 8'h10, "R7 R8 high pins");
        wr(8'hD7, 8'h00);

        // R11 set beats clear
        wr(8'hF5, 8'h01);
        @(negedge clk); pad_in = 6'h19;
        @(negedge clk);
        wr(8'hD7, 8'h00);
        rd(8'hD7, 8'h01, "R11 set wins");
        wr(8'hD7, 8'h00);
        rd(8'hD7, 8'h00, "R11 later clear");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule